// File: doc/BRIEF.md
# Dual-Mode Pipelined Booth Multiplier

This block multiplies signed two's-complement operands with radix-4 Booth recoding. The multiplier operand is scanned in overlapping three-bit groups, so a 16-bit operand yields eight partial products instead of sixteen. For each operation, a select input chooses between two uses of the same array. In full mode it forms one 32-bit product from two 16-bit operands. In split mode the two bytes of each input port are treated as two independent 8-bit operand pairs, and two 16-bit products are returned side by side.

The datapath has three register stages: recode and generate, reduce, then final add. A new operation may enter on every clock. The mode and truncate selects travel down the pipeline with their own operands.

An input check inspects the operands of each full-mode operation. When both operands fit in eight signed bits, the upper four partial products must be zero. Their registers are then held rather than reloaded, and the reduction stage substitutes zero for them. An optional truncated full mode works as follows:
- It skips the twelve lowest partial-product columns.
- It rounds the sum at bit 15, which compensates for the skipped columns.
- It returns only the upper half of the product.

Top module: `booth_dual_mul`

## Requirements
- R1: With split_sel=0 and trunc_sel=0, result equals the exact 32-bit signed product of op_a and op_b, including -32768 times -32768 and -32768 times 32767.
- R2: With split_sel=1, result[15:0] is the signed product of op_a[7:0] and op_b[7:0], and result[31:16] is the signed product of op_a[15:8] and op_b[15:8]. No carry or sign passes between the two halves, including at -128 times -128.
- R3: An operation whose in_valid is sampled at a rising edge shows out_valid=1 and its result after the third rising edge, counting the sampling edge. One operation is accepted per clock, and every accepted operation produces exactly one output.
- R4: In full mode, when op_a[15:7] and op_b[15:7] are each all zeros or all ones, the upper four partial-product registers keep their previous contents. The result is still the exact product, even directly after a wide operation.
- R5: With split_sel=0 and trunc_sel=1, result[15:0] reads zero, and result differs from the exact product by at most 2^15 + 8*(2^12-1) = 65528.
- R6: With split_sel=1, trunc_sel has no effect: the result is the exact pair of byte products described in R2.
- R7: Operations with different mode and truncate selects may follow one another on consecutive clocks, and each result follows the selects presented with its own operands.
- R8: While rst is high at a rising edge, out_valid and result are cleared to zero, and any operation already in flight is discarded.
- R9: On a clock whose final stage holds no operation, out_valid is 0 and result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are presented this cycle |
| split_sel | input | 1 | 1: two byte-wide products, 0: one 16-bit product |
| trunc_sel | input | 1 | 1: truncated, rounded full-mode product (ignored in split mode) |
| op_a | input | 16 | Multiplicand; in split mode bytes [7:0] and [15:8] are separate operands |
| op_b | input | 16 | Multiplier, Booth recoded; same byte packing as op_a |
| result | output | 32 | Product; in split mode low product in [15:0], high product in [31:16] |
| out_valid | output | 1 | result carries a finished operation |

## Verification
The gating of narrow operands and the full-width product can fall in the same cycle. A narrow full-mode operation entering directly behind a wide one leaves the held upper partial-product registers full of the previous operation's non-zero values. The reduction stage must discard them in that very cycle. The stimulus table places narrow operands such as -128 and 127 immediately after wide and split operations on consecutive clocks. Each result is judged bit-exactly against a behavioural signed multiply, together with its arrival exactly three edges after issue.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    localparam int OPW        = 16;
    localparam int HW         = OPW / 2;
    localparam int RW         = 2 * OPW;
    localparam int NPP        = OPW / 2;
    localparam int NPP_H      = NPP / 2;
    localparam int TRUNC_DROP = 12;
    localparam int BIAS_POS   = OPW - 1;

    typedef logic signed [RW-1:0] word_t;
    typedef logic [NPP-1:0][RW-1:0] pp_vec_t;

    typedef struct packed {
        logic split;
        logic trunc;
        logic narrow;
    } ctrl_t;

    typedef enum logic [2:0] {
        DIG_ZERO,
        DIG_P1,
        DIG_P2,
        DIG_M1,
        DIG_M2
    } digit_e;

    function automatic digit_e booth_code(input logic [2:0] grp);
        digit_e d;
        case (grp)
            3'b001, 3'b010: d = DIG_P1;
            3'b011:         d = DIG_P2;
            3'b100:         d = DIG_M2;
            3'b101, 3'b110: d = DIG_M1;
            default:        d = DIG_ZERO;
        endcase
        return d;
    endfunction

    function automatic word_t apply_digit(input word_t m, input digit_e d);
        word_t r;
        case (d)
            DIG_P1:  r = m;
            DIG_P2:  r = m <<< 1;
            DIG_M1:  r = -m;
            DIG_M2:  r = -(m <<< 1);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic fits_half(input logic [OPW-1:0] v);
        return (v[OPW-1:HW-1] == '0) || (v[OPW-1:HW-1] == '1);
    endfunction
endpackage

// File: rtl/bdm_ppgen.sv
module bdm_ppgen
    import bdm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           split_sel,
    input  logic           trunc_sel,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output pp_vec_t        pp_q,
    output ctrl_t          ctl_q,
    output logic           vld_q
);
    localparam logic [RW-1:0] DROP_MASK = {{(RW-TRUNC_DROP){1'b1}}, {TRUNC_DROP{1'b0}}};

    logic [OPW:0] bx;
    ctrl_t        ctl_d;
    logic         en_lo;
    logic         en_hi;

    assign bx = {op_b, 1'b0};

    always_comb begin
        ctl_d.split  = split_sel;
        ctl_d.trunc  = trunc_sel & ~split_sel;
        ctl_d.narrow = ~split_sel & fits_half(op_a) & fits_half(op_b);
    end

    assign en_lo = in_valid;
    assign en_hi = in_valid & ~ctl_d.narrow;

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        localparam bit IS_HI    = (i >= NPP_H);
        localparam bit FIRST_HI = (i == NPP_H);
        localparam int FULL_SH  = 2 * i;
        localparam int SPLIT_SH = IS_HI ? 2 * (i - NPP_H) : 2 * i;

        logic [2:0]    grp;
        word_t         mcand;
        word_t         raw;
        word_t         pp_d;
        logic [RW-1:0] pp_r;
        logic          ld;

        always_comb begin
            grp = bx[2*i+2 -: 3];
            if (split_sel && FIRST_HI) grp[0] = 1'b0;
            if (!split_sel)
                mcand = {{OPW{op_a[OPW-1]}}, op_a};
            else if (IS_HI)
                mcand = {{(RW-HW){op_a[OPW-1]}}, op_a[OPW-1:HW]};
            else
                mcand = {{(RW-HW){op_a[HW-1]}}, op_a[HW-1:0]};
            raw  = apply_digit(mcand, booth_code(grp));
            pp_d = split_sel ? (raw <<< SPLIT_SH) : (raw <<< FULL_SH);
            if (ctl_d.trunc) pp_d = pp_d & DROP_MASK;
        end

        assign ld = IS_HI ? en_hi : en_lo;

        always_ff @(posedge clk) begin
            if (rst)     pp_r <= '0;
            else if (ld) pp_r <= pp_d;
        end

        assign pp_q[i] = pp_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ctl_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) ctl_q <= ctl_d;
        end
    end

    // R4
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_d.narrow) |=> $stable(pp_q[NPP-1:NPP_H]));

    // R3
    issue_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> vld_q);
endmodule

// File: rtl/bdm_reduce.sv
module bdm_reduce
    import bdm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    vld_in,
    input  pp_vec_t pp_in,
    input  ctrl_t   ctl_in,
    output word_t   sum_lo_q,
    output word_t   sum_hi_q,
    output ctrl_t   ctl_q,
    output logic    vld_q
);
    word_t lo;
    word_t hi;

    always_comb begin
        lo = '0;
        hi = '0;
        for (int k = 0; k < NPP_H; k++) begin
            lo = lo + pp_in[k];
            hi = hi + pp_in[k+NPP_H];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            sum_lo_q <= '0;
            sum_hi_q <= '0;
            ctl_q    <= '0;
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                sum_lo_q <= lo;
                sum_hi_q <= ctl_in.narrow ? '0 : hi;
                ctl_q    <= ctl_in;
            end
        end
    end
endmodule

// File: rtl/bdm_finish.sv
module bdm_finish
    import bdm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_in,
    input  word_t         sum_lo,
    input  word_t         sum_hi,
    input  ctrl_t         ctl_in,
    output logic [RW-1:0] result,
    output logic          out_valid
);
    word_t          whole;
    logic [OPW-1:0] rnd_hi;
    logic [RW-1:0]  res_d;
    logic           trunc_q;

    always_comb begin
        whole  = sum_lo + sum_hi;
        rnd_hi = whole[RW-1:OPW] + OPW'(whole[BIAS_POS]);
        if (ctl_in.split)
            res_d = {sum_hi[OPW-1:0], sum_lo[OPW-1:0]};
        else if (ctl_in.trunc)
            res_d = {rnd_hi, {OPW{1'b0}}};
        else
            res_d = whole;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            trunc_q   <= 1'b0;
        end else begin
            out_valid <= vld_in;
            if (vld_in) begin
                result  <= res_d;
                trunc_q <= ctl_in.trunc;
            end
        end
    end

    // R5
    trunc_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && trunc_q) |-> (result[OPW-1:0] == '0));

    // R3
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        vld_in |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> (!out_valid && $stable(result)));

    // R4
    narrow_range_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_in && ctl_in.narrow && !ctl_in.trunc) |=>
        ((result[RW-1:BIAS_POS] == '0) || (result[RW-1:BIAS_POS] == '1)));
endmodule

// File: rtl/booth_dual_mul.sv
module booth_dual_mul
    import bdm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           split_sel,
    input  logic           trunc_sel,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic [RW-1:0]  result,
    output logic           out_valid
);
    pp_vec_t s1_pp;
    ctrl_t   s1_ctl;
    logic    s1_vld;
    word_t   s2_lo;
    word_t   s2_hi;
    ctrl_t   s2_ctl;
    logic    s2_vld;

    bdm_ppgen u_ppgen (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .split_sel (split_sel),
        .trunc_sel (trunc_sel),
        .op_a      (op_a),
        .op_b      (op_b),
        .pp_q      (s1_pp),
        .ctl_q     (s1_ctl),
        .vld_q     (s1_vld)
    );

    bdm_reduce u_reduce (
        .clk      (clk),
        .rst      (rst),
        .vld_in   (s1_vld),
        .pp_in    (s1_pp),
        .ctl_in   (s1_ctl),
        .sum_lo_q (s2_lo),
        .sum_hi_q (s2_hi),
        .ctl_q    (s2_ctl),
        .vld_q    (s2_vld)
    );

    bdm_finish u_finish (
        .clk       (clk),
        .rst       (rst),
        .vld_in    (s2_vld),
        .sum_lo    (s2_lo),
        .sum_hi    (s2_hi),
        .ctl_in    (s2_ctl),
        .result    (result),
        .out_valid (out_valid)
    );
endmodule

// File: tb/booth_dual_mul_bench.sv
`timescale 1ns/1ps
module booth_dual_mul_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        split_sel = 1'b0;
    logic        trunc_sel = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] result;
    logic        out_valid;

    booth_dual_mul u_booth_dual_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .split_sel(split_sel),
        .trunc_sel(trunc_sel), .op_a(op_a), .op_b(op_b),
        .result(result), .out_valid(out_valid)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    localparam int BOUND = 32768 + 8 * 4095;

    // entry: {gap, split, trunc, op_a, op_b}
    localparam int NV = 22;
    localparam logic [34:0] VEC [NV] = '{
        {3'b000, 16'h04D2, 16'hFDC9},
        {3'b000, 16'hFF80, 16'hFF80},
        {3'b000, 16'h8000, 16'h8000},
        {3'b000, 16'h8000, 16'h7FFF},
        {3'b000, 16'h0005, 16'hFFFD},
        {3'b000, 16'h7FFF, 16'h7FFF},
        {3'b000, 16'hFF80, 16'h007F},
        {3'b010, 16'h8080, 16'h8080},
        {3'b000, 16'h007F, 16'hFF80},
        {3'b010, 16'h8080, 16'h807F},
        {3'b010, 16'h7F80, 16'h8001},
        {3'b001, 16'h8000, 16'h8000},
        {3'b000, 16'hFFFF, 16'hFFFF},
        {3'b001, 16'h3039, 16'hA460},
        {3'b011, 16'h8080, 16'h8080},
        {3'b001, 16'hFF80, 16'hFF80},
        {3'b100, 16'h7FFF, 16'hFFFF},
        {3'b001, 16'h012C, 16'hFFFF},
        {3'b011, 16'hFF01, 16'h02FF},
        {3'b000, 16'hFFFE, 16'h0040},
        {3'b110, 16'h0180, 16'hFF7F},
        {3'b000, 16'h8000, 16'hFFFF}
    };

    logic [34:0] q_vec [64];
    int          q_cyc [64];
    int          wr = 0;
    int          rd = 0;

    function automatic bit fits8(input logic [15:0] v);
        return (v[15:7] == 9'h000) || (v[15:7] == 9'h1FF);
    endfunction

    task automatic check_out(input logic [34:0] v, input int icyc);
        logic [15:0] a;
        logic [15:0] b;
        int          p;
        int          plo;
        int          phi;
        longint      diff;
        logic [31:0] expv;
        string       tag;
        bit          ok;
        a = v[31:16];
        b = v[15:0];
        if (v[33]) begin
            plo  = int'($signed(a[7:0])) * int'($signed(b[7:0]));
            phi  = int'($signed(a[15:8])) * int'($signed(b[15:8]));
            expv = {phi[15:0], plo[15:0]};
            tag  = v[32] ? "R6" : "R2";
            ok   = (result == expv);
        end else begin
            p    = int'($signed(a)) * int'($signed(b));
            expv = p;
            if (v[32]) begin
                tag  = "R5";
                diff = longint'($signed(result)) - longint'(p);
                if (diff < 0) diff = -diff;
                ok   = (result[15:0] == 16'h0) && (diff <= BOUND);
            end else begin
                tag = (fits8(a) && fits8(b)) ? "R4" : "R1";
                ok  = (result == expv);
            end
        end
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s R7 op %0d: got %h expected %h", tag, rd, result, expv);
        end
        // R3 latency
        total++;
        if (cyc - icyc != 3) begin
            bad++;
            $display("FAIL R3 op %0d latency: got %0d expected 3", rd, cyc - icyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd >= wr) begin
                total++;
                bad++;
                $display("FAIL R3 unexpected output: got %h expected none", result);
            end else begin
                check_out(q_vec[rd], q_cyc[rd]);
                rd++;
            end
        end
    end

    task automatic issue(input logic [34:0] v);
        if (v[34]) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid  = 1'b1;
        split_sel = v[33];
        trunc_sel = v[32];
        op_a      = v[31:16];
        op_b      = v[15:0];
        q_vec[wr] = v;
        q_cyc[wr] = cyc;
        wr++;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R8 reset state
        total++;
        if (out_valid !== 1'b0 || result !== 32'h0) begin
            bad++;
            $display("FAIL R8 reset: got valid=%b result=%h expected 0 0", out_valid, result);
        end
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) issue(VEC[k]);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);

        // R3 every operation produced one output
        total++;
        if (rd != wr) begin
            bad++;
            $display("FAIL R3 output count: got %0d expected %0d", rd, wr);
        end

        // R9 idle: no valid, result held
        held = result;
        for (int k = 0; k < 5; k++) begin
            total++;
            if (out_valid !== 1'b0 || result !== held) begin
                bad++;
                $display("FAIL R9 idle: got valid=%b result=%h expected 0 %h", out_valid, result, held);
            end
            @(negedge clk);
        end

        // R8 reset discards an operation in flight
        in_valid = 1'b1; split_sel = 1'b0; trunc_sel = 1'b0;
        op_a = 16'h1234; op_b = 16'h4321;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || result !== 32'h0) begin
            bad++;
            $display("FAIL R8 mid-flight reset: got valid=%b result=%h expected 0 0", out_valid, result);
        end
        rst = 1'b0;
        repeat (5) @(negedge clk);
        total++;
        if (rd != wr) begin
            bad++;
            $display("FAIL R8 discarded op emerged: got %0d outputs expected %0d", rd, wr);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule